// File: doc/BRIEF.md
# Posted Column Command Scheduler

This block times the column-command path of a double-data-rate memory bank. A read or write command may be presented as soon as the row is activated, or at any point before the row-to-column delay has run out. The block holds each accepted command for the programmed additive latency and then raises a one-cycle internal issue strobe that goes to the array. From the same held command it derives two data windows. One window marks the cycles in which read data is valid. The other marks the cycles in which write data is expected. Each window lasts for the burst duration in clocks.

A single row-open timer counts the clocks since the last activate. It checks the command against the programmed row-to-column delay. If a command arrives too early with no additive latency, or reaches the array before the delay has elapsed, a violation strobe is raised. The latencies, the burst length and the delay are static settings. Each command strobe is one cycle wide, and read and write are never asserted together.

Top module: `posted_cas_sched`

## Requirements
- R1: A command accepted in cycle t produces `iss_o` high for exactly cycle t+AL. With AL=0 this is the acceptance cycle itself. `iss_wr_o` is high together with `iss_o` only for a write.
- R2: For a read accepted in cycle t, `rd_win_o` first rises in cycle t+AL+CL.
- R3: For a write accepted in cycle t, `wr_win_o` first rises in cycle t+AL+CL-1, one cycle before the matching read window would.
- R4: Each window stays high for 2 cycles when `bl8_i`=0 (burst of 4) and for 4 cycles when `bl8_i`=1 (burst of 8).
- R5: Commands of the same kind spaced by exactly the window length give one continuous window, with no gap cycle.
- R6: The elapsed count in a cycle is the number of cycles since the last activate. It is 0 in the activate cycle itself. A command with AL=0 and an elapsed count below `trcd_i` raises `viol_o` in the next cycle.
- R7: An issue whose elapsed count is below `trcd_i` raises `viol_o` in the cycle after the issue. An early command whose AL carries its issue to or past `trcd_i` raises no flag.
- R8: With no activate since reset, the elapsed count is 0, so any issue with `trcd_i` > 0 is flagged.
- R9: Several commands can be held at once. Each command issues in its own cycle, and each keeps its own read or write type.
- R10: Reset clears all held commands and drives `iss_o`, both windows and `viol_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_i | input | 1 | Row activate strobe |
| rd_i | input | 1 | Read command strobe |
| wr_i | input | 1 | Write command strobe |
| al_i | input | AL_W | Additive latency, 0..MAX_AL |
| cl_i | input | CL_W | CAS latency, 2..MAX_CL |
| bl8_i | input | 1 | 1 selects a burst of 8, 0 a burst of 4 |
| trcd_i | input | TRCD_W | Row-to-column delay in clocks |
| iss_o | output | 1 | Internal column issue pulse |
| iss_wr_o | output | 1 | The issued command is a write |
| rd_win_o | output | 1 | Read data valid window |
| wr_win_o | output | 1 | Write data expected window |
| viol_o | output | 1 | Timing violation strobe |

## Verification
A table of single commands varies the additive latency, the CAS latency, the burst length, the delay and the gap from the activate. This separates an issue or window that is off by one, a write window that is placed the same as a read window, and a wrong window length. Pairs of commands, including a posted early command that is still issued in time, separate the two violation conditions from the case that must not be flagged. Back-to-back reads and writes expose gaps in the windows. Commands that overlap in the hold line, and a reset applied while a command is held, show whether commands are kept separate and whether reset flushes them.

// File: rtl/pcs_pkg.sv
`timescale 1ns/1ps
package pcs_pkg;
  localparam int MAX_LEN = 4;

  function automatic logic [2:0] burst_win(input logic bl8);
    return bl8 ? 3'd4 : 3'd2;
  endfunction
endpackage

// File: rtl/pcs_cmd_delay.sv
`timescale 1ns/1ps
module pcs_cmd_delay #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_i,
  output logic [DEPTH:0]   tap_o
);
  logic [DEPTH:1] hold_q;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else     hold_q <= {hold_q[DEPTH-1:1], cmd_i};
  end

  assign tap_o = {hold_q, cmd_i};
endmodule

// File: rtl/pcs_window_gen.sv
`timescale 1ns/1ps
module pcs_window_gen #(
  parameter int DEPTH = 16,
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH:0]   hist_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic [2:0]       len_i,
  output logic             win_o
);
  logic win_d;

  always_comb begin
    win_d = 1'b0;
    for (int j = 0; j < pcs_pkg::MAX_LEN; j++) begin
      int idx;
      idx = int'(lat_i) + j - 1;
      if (j < int'(len_i) && idx >= 0 && idx <= DEPTH)
        win_d = win_d | hist_i[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) win_o <= 1'b0;
    else     win_o <= win_d;
  end

  AST_WIN_MIN_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(win_o) |=> win_o); // R4
endmodule

// File: rtl/pcs_row_timer.sv
`timescale 1ns/1ps
module pcs_row_timer #(
  parameter int TRCD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_i,
  input  logic [TRCD_W-1:0] trcd_i,
  output logic              early_o
);
  localparam logic [TRCD_W-1:0] SAT = '1;

  logic [TRCD_W-1:0] since_q;
  logic [TRCD_W-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst)                            since_q <= '0;
    else if (act_i)                     since_q <= TRCD_W'(1);
    else if (since_q != '0 && since_q != SAT) since_q <= since_q + 1'b1;
  end

  assign elapsed = act_i ? '0 : since_q;
  assign early_o = elapsed < trcd_i;

  AST_TIMER_HOLDS_AT_SAT: assert property (@(posedge clk) disable iff (rst)
    (since_q == SAT && !act_i) |=> since_q == SAT); // R7
  AST_ACT_STARTS_COUNT: assert property (@(posedge clk) disable iff (rst)
    act_i |=> since_q == TRCD_W'(1)); // R6
endmodule

// File: rtl/posted_cas_sched.sv
`timescale 1ns/1ps
module posted_cas_sched #(
  parameter int MAX_AL = 6,
  parameter int MAX_CL = 7,
  parameter int TRCD_W = 4,
  parameter int AL_W   = $clog2(MAX_AL + 1),
  parameter int CL_W   = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [AL_W-1:0]   al_i,
  input  logic [CL_W-1:0]   cl_i,
  input  logic              bl8_i,
  input  logic [TRCD_W-1:0] trcd_i,
  output logic              iss_o,
  output logic              iss_wr_o,
  output logic              rd_win_o,
  output logic              wr_win_o,
  output logic              viol_o
);
  localparam int DEPTH = MAX_AL + MAX_CL + pcs_pkg::MAX_LEN - 1;
  localparam int LAT_W = $clog2(MAX_AL + MAX_CL + 1);

  logic [1:0]       cmd_in;
  logic [DEPTH:0]   tap [2];
  logic [LAT_W-1:0] lat [2];
  logic [1:0]       win;
  logic [LAT_W-1:0] rd_lat;
  logic [2:0]       len;
  logic             early;
  logic             viol_d;
  logic             iss_rd;

  assign cmd_in = {wr_i, rd_i};
  assign rd_lat = LAT_W'(al_i) + LAT_W'(cl_i);
  assign lat[0] = rd_lat;
  assign lat[1] = rd_lat - 1'b1;
  assign len    = pcs_pkg::burst_win(bl8_i);

  for (genvar g = 0; g < 2; g++) begin : g_kind
    pcs_cmd_delay #(.DEPTH(DEPTH)) u_dly (
      .clk   (clk),
      .rst   (rst),
      .cmd_i (cmd_in[g]),
      .tap_o (tap[g])
    );
    pcs_window_gen #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_win (
      .clk    (clk),
      .rst    (rst),
      .hist_i (tap[g]),
      .lat_i  (lat[g]),
      .len_i  (len),
      .win_o  (win[g])
    );
  end

  pcs_row_timer #(.TRCD_W(TRCD_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .act_i   (act_i),
    .trcd_i  (trcd_i),
    .early_o (early)
  );

  assign iss_rd   = tap[0][al_i];
  assign iss_wr_o = tap[1][al_i];
  assign iss_o    = iss_rd | iss_wr_o;
  assign rd_win_o = win[0];
  assign wr_win_o = win[1];

  // early command with nothing to hold it, or an issue before the delay ran out
  assign viol_d = (iss_o && early) || ((rd_i || wr_i) && al_i == '0 && early);

  always_ff @(posedge clk) begin
    if (rst) viol_o <= 1'b0;
    else     viol_o <= viol_d;
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
    !(rd_i && wr_i)); // R1
  AST_AL0_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ((rd_i || wr_i) && al_i == '0) |-> iss_o); // R1
  AST_EARLY_AL0_FLAG: assert property (@(posedge clk) disable iff (rst)
    ((rd_i || wr_i) && al_i == '0 && early) |=> viol_o); // R6
  AST_ISSUE_TYPE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({iss_rd, iss_wr_o})); // R9
endmodule

// File: tb/posted_cas_sched_test.sv
`timescale 1ns/1ps
module posted_cas_sched_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic act = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [2:0] al = '0;
  logic [2:0] cl = 3'd2;
  logic bl8 = 1'b0;
  logic [3:0] trcd = '0;
  logic iss, iss_wr, rdw, wrw, viol;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  posted_cas_sched uut (
    .clk(clk), .rst(rst), .act_i(act), .rd_i(rd), .wr_i(wr),
    .al_i(al), .cl_i(cl), .bl8_i(bl8), .trcd_i(trcd),
    .iss_o(iss), .iss_wr_o(iss_wr), .rd_win_o(rdw), .wr_win_o(wrw), .viol_o(viol)
  );

  typedef struct packed {
    logic [2:0] al;
    logic [2:0] cl;
    logic       bl8;
    logic [3:0] trcd;
    logic [2:0] gap;
    logic       is_wr;
    logic       viol;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 3'd3, 1'b0, 4'd2, 3'd2, 1'b0, 1'b0},
    '{3'd0, 3'd3, 1'b0, 4'd4, 3'd2, 1'b0, 1'b1},
    '{3'd2, 3'd3, 1'b0, 4'd3, 3'd1, 1'b0, 1'b0},
    '{3'd2, 3'd4, 1'b1, 4'd4, 3'd1, 1'b1, 1'b1},
    '{3'd4, 3'd5, 1'b1, 4'd5, 3'd1, 1'b0, 1'b0},
    '{3'd3, 3'd2, 1'b0, 4'd3, 3'd0, 1'b1, 1'b0},
    '{3'd6, 3'd7, 1'b1, 4'd6, 3'd1, 1'b1, 1'b0},
    '{3'd1, 3'd2, 1'b1, 4'd2, 3'd1, 1'b1, 1'b0}
  };

  task automatic chk(input logic got, input logic exp, input string tag, input int cyc);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%b expected=%b", tag, cyc, got, exp);
    end
  endtask

  // drive one cycle's inputs at the falling edge, then wait until just before the rising edge
  task automatic step(input logic a, input logic r, input logic w);
    @(negedge clk);
    act = a; rd = r; wr = w;
    #4;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; act = 1'b0; rd = 1'b0; wr = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] a, input logic [2:0] c, input logic b, input logic [3:0] t);
    al = a; cl = c; bl8 = b; trcd = t;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R10: outputs low after reset
    cfg(3'd0, 3'd2, 1'b0, 4'd0);
    do_reset();
    step(1'b0, 1'b0, 1'b0);
    chk(iss, 1'b0, "R10 iss after reset", 0);
    chk(rdw, 1'b0, "R10 rd_win after reset", 0);
    chk(wrw, 1'b0, "R10 wr_win after reset", 0);
    chk(viol, 1'b0, "R10 viol after reset", 0);

    // table walk: R1 R2 R3 R4 R6 R7
    for (int v = 0; v < 8; v++) begin
      vec_t t;
      int iss_c, rs, ws, ln;
      t = VECS[v];
      cfg(t.al, t.cl, t.bl8, t.trcd);
      do_reset();
      iss_c = int'(t.gap) + int'(t.al);
      rs = iss_c + int'(t.cl);
      ws = rs - 1;
      ln = t.bl8 ? 4 : 2;
      for (int c = 0; c < 30; c++) begin
        logic cmd;
        cmd = (c == int'(t.gap));
        step(c == 0, cmd && !t.is_wr, cmd && t.is_wr);
        chk(iss, c == iss_c, "R1 issue", c);
        chk(iss_wr, (c == iss_c) && t.is_wr, "R1 issue type", c);
        chk(rdw, !t.is_wr && c >= rs && c < rs + ln, "R2/R4 read window", c);
        chk(wrw, t.is_wr && c >= ws && c < ws + ln, "R3/R4 write window", c);
        chk(viol, t.viol && c == iss_c + 1, "R6/R7 violation", c);
      end
    end

    // R5: reads spaced by the window length, burst of 4
    cfg(3'd1, 3'd3, 1'b0, 4'd1);
    do_reset();
    for (int c = 0; c < 14; c++) begin
      step(c == 0, c == 2 || c == 4 || c == 6, 1'b0);
      if (c >= 5 && c <= 12) chk(rdw, c >= 6 && c <= 11, "R5 seamless read", c);
    end

    // R5: writes spaced by the window length, burst of 8
    cfg(3'd0, 3'd3, 1'b1, 4'd1);
    do_reset();
    for (int c = 0; c < 14; c++) begin
      step(c == 0, 1'b0, c == 2 || c == 6);
      if (c >= 3 && c <= 12) chk(wrw, c >= 4 && c <= 11, "R5 seamless write", c);
    end

    // R9: two commands held at once keep their cycles and types
    cfg(3'd5, 3'd2, 1'b0, 4'd1);
    do_reset();
    for (int c = 0; c < 12; c++) begin
      step(c == 0, c == 2, c == 3);
      if (c >= 6 && c <= 9) begin
        chk(iss, c == 7 || c == 8, "R9 issue in flight", c);
        chk(iss_wr, c == 8, "R9 issue type in flight", c);
      end
    end

    // R8: no activate since reset
    cfg(3'd2, 3'd3, 1'b0, 4'd1);
    do_reset();
    for (int c = 0; c < 7; c++) begin
      step(1'b0, c == 1, 1'b0);
      chk(viol, c == 4, "R8 no activate", c);
    end

    // R10: reset while a command is held
    cfg(3'd6, 3'd7, 1'b0, 4'd1);
    do_reset();
    for (int c = 0; c < 3; c++) step(c == 0, c == 1, 1'b0);
    do_reset();
    for (int c = 0; c < 20; c++) begin
      step(1'b0, 1'b0, 1'b0);
      chk(iss | rdw | wrw | viol, 1'b0, "R10 flush", c);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule